// File: doc/BRIEF.md
# Configurable GPIO Port Controller

A controller for one port of general-purpose pins. Each pin is placed on its own in one of four drive modes: high-impedance input, push-pull output, open-drain output, or quasi-bidirectional. In quasi-bidirectional mode the pin pulls low strongly for a 0. For a 1 it drives high for a single clock and then lets go, so that only a weak pull-up holds the line. Software programs the block through a small register port with single-cycle writes and combinational reads. Toward the pad the block drives an output enable, an output level and a weak pull-up enable for every pin, and it receives the raw pad levels.

Pad levels pass through a two-stage synchronizer and then feed a per-pin interrupt detector. Each pin is set for edge or level triggering. In edge mode the polarity bit picks rising or falling, and the flag stays set until software writes 1 to clear it. In level mode the polarity bit picks high or low, and pending simply follows the pin. The port interrupt is the OR of enabled pending pins. Any pin with its interrupt enabled can also wake the system; there is no separate wake enable. Reset modes come from two straps. One strap picks input or quasi-bidirectional for every pin. A second strap either lets the special pin (pin 8) follow the first strap or forces it to push-pull driving low.

Every pin has its own driver state machine. Its states are ST_HIZ, ST_PP_LO, ST_PP_HI, ST_OD_LO, ST_OD_REL, ST_QB_LO, ST_QB_KICK and ST_QB_WEAK. Input mode goes to ST_HIZ. Push-pull goes to ST_PP_LO or ST_PP_HI according to the data bit. Open-drain goes to ST_OD_LO or ST_OD_REL according to the data bit. In quasi mode, a data bit of 0 goes to ST_QB_LO. A data bit of 1 goes to ST_QB_KICK from any state other than ST_QB_KICK or ST_QB_WEAK. A data bit of 1 goes from ST_QB_KICK or ST_QB_WEAK to ST_QB_WEAK.

Top module: `gpio_port_ctrl`

## Requirements
- R1: Register addresses: 0 mode (2 bits per pin at bits 2i+1:2i, 00 input, 01 push-pull, 10 open-drain, 11 quasi), 1 data out, 2 interrupt enable, 3 trigger type (1 level, 0 edge), 4 polarity (1 rising/high, 0 falling/low), 5 pending (write 1 clears edge flags), 6 synchronized pin levels. When strap_in_mode=0, every pin other than the special pin resets to quasi mode with data 1: pull-up on and no drive.
- R2: When strap_in_mode=1, every pin other than the special pin resets to input mode (mode bits 00). Output enable and pull-up are both off.
- R3: When strap_special_follow=0, the special pin resets to push-pull with data 0 and drives low. When strap_special_follow=1, it follows strap_in_mode.
- R4: Push-pull mode always asserts output enable, drives the data bit, and never enables the pull-up.
- R5: Open-drain mode asserts output enable only when the data bit is 0. The output level is always 0 and the pull-up is off.
- R6: Quasi mode drives low with the pull-up off for data 0. When data becomes 1, the pin drives high with the pull-up on for exactly one clock, then releases and keeps only the pull-up.
- R7: A write to mode or data reaches the pad outputs one clock after the register updates.
- R8: The pin-level register shows a pad level two clocks after that level is applied.
- R9: An enabled edge pin sets a sticky pending flag on the selected edge only. The flag is cleared by writing 1 to its pending bit.
- R10: An enabled level pin is pending while its synchronized level matches the polarity, and stops being pending when the level no longer matches.
- R11: irq_o is the OR of pending pins whose interrupt is enabled. A disabled pin never raises irq_o or pending.
- R12: wake_o is asserted whenever irq_o is, and for an enabled edge pin it rises one clock before irq_o, as soon as the synchronized edge appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_in_mode | input | 1 | Reset mode for all pins: 0 quasi, 1 input |
| strap_special_follow | input | 1 | 0: special pin resets push-pull low; 1: follows strap_in_mode |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pad_in | input | 16 | Raw pad levels |
| pad_oe | output | 16 | Per-pin output enable |
| pad_out | output | 16 | Per-pin output level |
| pad_pu | output | 16 | Per-pin weak pull-up enable |
| irq_o | output | 1 | Port interrupt |
| wake_o | output | 1 | Wake-up request |

## Verification
The in-RTL assertions check on every cycle that a quasi drive-high never lasts more than one clock. They also check that the pull-up never sits alongside a strong low, that push-pull and open-drain pads drive as their settled mode requires, that edge flags never drop without a clear write, and that the interrupt needs an enabled pin. Only the bench scenarios can show the strap-dependent reset values, the exact write-to-pad and pad-to-register latencies, the direction selection of edges, the level tracking, and the one-clock lead of wake over interrupt.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    typedef enum logic [1:0] {
        PM_INPUT     = 2'b00,
        PM_PUSHPULL  = 2'b01,
        PM_OPENDRAIN = 2'b10,
        PM_QUASI     = 2'b11
    } pin_mode_e;

    typedef enum logic [2:0] {
        ST_HIZ,
        ST_PP_LO,
        ST_PP_HI,
        ST_OD_LO,
        ST_OD_REL,
        ST_QB_LO,
        ST_QB_KICK,
        ST_QB_WEAK
    } pin_state_e;

    localparam logic [2:0] REG_MODE  = 3'd0;
    localparam logic [2:0] REG_DOUT  = 3'd1;
    localparam logic [2:0] REG_IEN   = 3'd2;
    localparam logic [2:0] REG_ITYPE = 3'd3;
    localparam logic [2:0] REG_IPOL  = 3'd4;
    localparam logic [2:0] REG_IPEND = 3'd5;
    localparam logic [2:0] REG_PIN   = 3'd6;

endpackage

// File: rtl/gpio_pin_fsm.sv
module gpio_pin_fsm
    import gpio_port_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  pin_state_e rst_state,
    input  pin_mode_e  mode,
    input  logic       dout,
    output logic       pad_oe,
    output logic       pad_out,
    output logic       pad_pu
);

    pin_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= rst_state;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (mode)
            PM_INPUT:     state_d = ST_HIZ;
            PM_PUSHPULL:  state_d = dout ? ST_PP_HI : ST_PP_LO;
            PM_OPENDRAIN: state_d = dout ? ST_OD_REL : ST_OD_LO;
            PM_QUASI: begin
                if (!dout)
                    state_d = ST_QB_LO;
                else if (state_q == ST_QB_KICK || state_q == ST_QB_WEAK)
                    state_d = ST_QB_WEAK;
                else
                    state_d = ST_QB_KICK;
            end
            default:      state_d = ST_HIZ;
        endcase
    end

    always_comb begin
        pad_oe  = 1'b0;
        pad_out = 1'b0;
        pad_pu  = 1'b0;
        unique case (state_q)
            ST_HIZ:     ;
            ST_PP_LO:   pad_oe = 1'b1;
            ST_PP_HI:   begin pad_oe = 1'b1; pad_out = 1'b1; end
            ST_OD_LO:   pad_oe = 1'b1;
            ST_OD_REL:  ;
            ST_QB_LO:   pad_oe = 1'b1;
            ST_QB_KICK: begin pad_oe = 1'b1; pad_out = 1'b1; pad_pu = 1'b1; end
            ST_QB_WEAK: pad_pu = 1'b1;
            default:    ;
        endcase
    end

    // R6: the strong high in quasi mode never lasts two clocks
    a_r6_kick_single: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe && pad_out && pad_pu) |=> !(pad_oe && pad_out && pad_pu));

    // R6: pull-up never fights a strong low
    a_r6_pullup_not_low: assert property (@(posedge clk) disable iff (!rst_n)
        pad_pu |-> !(pad_oe && !pad_out));

    // R4: a settled push-pull pin always drives
    a_r4_pushpull_drives: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == PM_PUSHPULL && $past(mode) == PM_PUSHPULL) |-> (pad_oe && !pad_pu));

    // R5: a settled open-drain pin never drives high and drives only for a 0
    a_r5_opendrain_low_only: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == PM_OPENDRAIN && $past(mode) == PM_OPENDRAIN)
        |-> (!pad_out && (pad_oe == !$past(dout))));

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pad_in,
    output logic [W-1:0] lvl,
    output logic [W-1:0] prev
);

    logic [W-1:0] meta_q, lvl_q, prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            lvl_q  <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= pad_in;
            lvl_q  <= meta_q;
            prev_q <= lvl_q;
        end
    end

    assign lvl  = lvl_q;
    assign prev = prev_q;

endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    input  logic [W-1:0] prev,
    input  logic [W-1:0] en,
    input  logic [W-1:0] is_level,
    input  logic [W-1:0] pol,
    input  logic         clr_we,
    input  logic [W-1:0] clr_mask,
    output logic [W-1:0] pend,
    output logic         irq,
    output logic         wake
);

    logic [W-1:0] flag_q, hit, lvl_pend, clr;

    always_comb begin
        hit      = en & ~is_level & ((pol & lvl & ~prev) | (~pol & ~lvl & prev));
        lvl_pend = en & is_level & ~(lvl ^ pol);
        clr      = clr_we ? clr_mask : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= (flag_q & ~clr) | hit;
    end

    assign pend = flag_q | lvl_pend;
    assign irq  = |(pend & en);
    assign wake = irq | (|hit);

    // R9: an edge flag drops only through a clear write
    a_r9_edge_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_we |=> (($past(flag_q) & ~flag_q) == '0));

    // R11: interrupt needs at least one enabled pin
    a_r11_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (en != '0));

endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
    import gpio_port_pkg::*;
#(
    parameter int NPINS       = 16,
    parameter int DW          = 32,
    parameter int AW          = 3,
    parameter int SPECIAL_PIN = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strap_in_mode,
    input  logic             strap_special_follow,
    input  logic             bus_we,
    input  logic [AW-1:0]    bus_addr,
    input  logic [DW-1:0]    bus_wdata,
    output logic [DW-1:0]    bus_rdata,
    input  logic [NPINS-1:0] pad_in,
    output logic [NPINS-1:0] pad_oe,
    output logic [NPINS-1:0] pad_out,
    output logic [NPINS-1:0] pad_pu,
    output logic             irq_o,
    output logic             wake_o
);

    localparam int MW = 2 * NPINS;

    logic [MW-1:0]    mode_q, rst_mode;
    logic [NPINS-1:0] dout_q, rst_dout;
    logic [NPINS-1:0] ien_q, itype_q, ipol_q;
    logic [NPINS-1:0] lvl, prev, pend;
    logic             special_forced;

    assign special_forced = !strap_special_follow;

    always_comb begin
        for (int i = 0; i < NPINS; i++) begin
            if (i == SPECIAL_PIN && special_forced) begin
                rst_mode[2*i +: 2] = PM_PUSHPULL;
                rst_dout[i]        = 1'b0;
            end else begin
                rst_mode[2*i +: 2] = strap_in_mode ? PM_INPUT : PM_QUASI;
                rst_dout[i]        = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q  <= rst_mode;
            dout_q  <= rst_dout;
            ien_q   <= '0;
            itype_q <= '0;
            ipol_q  <= '0;
        end else if (bus_we) begin
            case (bus_addr)
                REG_MODE:  mode_q  <= bus_wdata[MW-1:0];
                REG_DOUT:  dout_q  <= bus_wdata[NPINS-1:0];
                REG_IEN:   ien_q   <= bus_wdata[NPINS-1:0];
                REG_ITYPE: itype_q <= bus_wdata[NPINS-1:0];
                REG_IPOL:  ipol_q  <= bus_wdata[NPINS-1:0];
                default:   ;
            endcase
        end
    end

    always_comb begin
        case (bus_addr)
            REG_MODE:  bus_rdata = DW'(mode_q);
            REG_DOUT:  bus_rdata = DW'(dout_q);
            REG_IEN:   bus_rdata = DW'(ien_q);
            REG_ITYPE: bus_rdata = DW'(itype_q);
            REG_IPOL:  bus_rdata = DW'(ipol_q);
            REG_IPEND: bus_rdata = DW'(pend);
            REG_PIN:   bus_rdata = DW'(lvl);
            default:   bus_rdata = '0;
        endcase
    end

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        pin_state_e rst_state;
        always_comb begin
            if (i == SPECIAL_PIN && special_forced) rst_state = ST_PP_LO;
            else if (strap_in_mode)                 rst_state = ST_HIZ;
            else                                    rst_state = ST_QB_WEAK;
        end

        gpio_pin_fsm u_pin (
            .clk       (clk),
            .rst_n     (rst_n),
            .rst_state (rst_state),
            .mode      (pin_mode_e'(mode_q[2*i +: 2])),
            .dout      (dout_q[i]),
            .pad_oe    (pad_oe[i]),
            .pad_out   (pad_out[i]),
            .pad_pu    (pad_pu[i])
        );
    end

    gpio_in_sync #(.W(NPINS)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pad_in (pad_in),
        .lvl    (lvl),
        .prev   (prev)
    );

    gpio_irq_unit #(.W(NPINS)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .lvl      (lvl),
        .prev     (prev),
        .en       (ien_q),
        .is_level (itype_q),
        .pol      (ipol_q),
        .clr_we   (bus_we && bus_addr == REG_IPEND),
        .clr_mask (bus_wdata[NPINS-1:0]),
        .pend     (pend),
        .irq      (irq_o),
        .wake     (wake_o)
    );

    // R12: every interrupt is also a wake request
    a_r12_wake_covers_irq: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> wake_o);

endmodule

// File: tb/gpio_port_ctrl_tb.sv
module gpio_port_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strap_in_mode = 1'b0;
    logic        strap_special_follow = 1'b0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] pad_in = '0;
    logic [15:0] pad_oe, pad_out, pad_pu;
    logic        irq_o, wake_o;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    string       q_req[$];
    int          q_sel[$];
    logic [31:0] q_exp[$];

    localparam int S_OE = 0, S_OUT = 1, S_PU = 2, S_RD = 3, S_IRQ = 4, S_WAKE = 5;

    always #2 clk = ~clk;

    gpio_port_ctrl u_dut (
        .clk(clk), .rst_n(rst_n),
        .strap_in_mode(strap_in_mode), .strap_special_follow(strap_special_follow),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu),
        .irq_o(irq_o), .wake_o(wake_o)
    );

    function automatic logic [31:0] observe(int sel);
        case (sel)
            S_OE:    return {16'h0, pad_oe};
            S_OUT:   return {16'h0, pad_out};
            S_PU:    return {16'h0, pad_pu};
            S_RD:    return bus_rdata;
            S_IRQ:   return {31'h0, irq_o};
            default: return {31'h0, wake_o};
        endcase
    endfunction

    // monitor: pops and compares at the negedge after the push
    always @(negedge clk) begin
        while (q_sel.size() > 0) begin
            string       r;
            int          s;
            logic [31:0] e, a;
            r = q_req.pop_front();
            s = q_sel.pop_front();
            e = q_exp.pop_front();
            a = observe(s);
            n_chk++;
            if (a !== e) begin
                n_err++;
                $display("FAIL %s sel=%0d actual=%h expected=%h", r, s, a, e);
            end
        end
    end

    task automatic expect_val(string r, int s, logic [31:0] e);
        q_req.push_back(r); q_sel.push_back(s); q_exp.push_back(e);
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] d);
        step();
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        step();
        bus_we = 1'b0;
    endtask

    task automatic pads(string r, logic [15:0] oe, logic [15:0] o, logic [15:0] pu);
        expect_val(r, S_OE, {16'h0, oe});
        expect_val(r, S_OUT, {16'h0, o});
        expect_val(r, S_PU, {16'h0, pu});
    endtask

    task automatic do_reset(logic sm, logic sf);
        rst_n = 1'b0; strap_in_mode = sm; strap_special_follow = sf;
        step(); step();
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        // R1 / R3: quasi reset, special pin forced push-pull low
        do_reset(1'b0, 1'b0);
        pads("R1_R3 reset quasi + special low", 16'h0100, 16'h0000, 16'hFEFF);
        bus_addr = 3'd0;
        expect_val("R1 mode reset", S_RD, 32'hFFFD_FFFF);
        step(); bus_addr = 3'd1;
        expect_val("R3 dout reset", S_RD, 32'h0000_FEFF);
        step();

        // R2 / R3: input reset, special follows
        do_reset(1'b1, 1'b1);
        pads("R2_R3 reset input", 16'h0, 16'h0, 16'h0);
        bus_addr = 3'd0;
        expect_val("R2 mode reset", S_RD, 32'h0);
        step();

        // pin0 push-pull, pin1 open-drain, pin2 quasi; dout all ones
        wr(3'd0, 32'h0000_0039);
        pads("R7 pad unchanged one clock", 16'h0, 16'h0, 16'h0);
        step();
        pads("R4_R6 pp high, od released, quasi kick", 16'h0005, 16'h0005, 16'h0004);
        step();
        pads("R6 quasi weak after kick", 16'h0001, 16'h0001, 16'h0004);
        wr(3'd1, 32'h0);
        step();
        pads("R4_R5_R6 all low", 16'h0007, 16'h0000, 16'h0000);
        wr(3'd1, 32'h0000_0004);
        step();
        pads("R6 kick from low", 16'h0007, 16'h0004, 16'h0004);
        step();
        pads("R5_R6 weak, od still low", 16'h0003, 16'h0000, 16'h0004);

        // R8 synchronizer latency
        bus_addr = 3'd6;
        pad_in[4] = 1'b1;
        expect_val("R8 pin level before", S_RD, 32'h0);
        step();
        expect_val("R8 pin level after 1", S_RD, 32'h0);
        step();
        expect_val("R8 pin level after 2", S_RD, 32'h0000_0010);

        // R9 / R12 rising edge on pin5
        wr(3'd2, 32'h0000_0020);
        wr(3'd3, 32'h0);
        wr(3'd4, 32'h0000_0020);
        pad_in[5] = 1'b1;
        step();
        expect_val("R12 wake not yet", S_WAKE, 32'h0);
        step();
        expect_val("R12 wake leads", S_WAKE, 32'h1);
        expect_val("R12 irq one later", S_IRQ, 32'h0);
        step();
        expect_val("R9 rising edge irq", S_IRQ, 32'h1);
        pad_in[5] = 1'b0;
        step(); step(); step();
        expect_val("R9 sticky", S_IRQ, 32'h1);
        bus_addr = 3'd5;
        expect_val("R9 pending bit", S_RD, 32'h0000_0020);
        wr(3'd5, 32'h0000_0020);
        expect_val("R9 cleared by write 1", S_IRQ, 32'h0);

        // R9 falling select ignores rise
        wr(3'd4, 32'h0);
        pad_in[5] = 1'b1;
        step(); step(); step();
        expect_val("R9 falling ignores rise", S_IRQ, 32'h0);
        pad_in[5] = 1'b0;
        step(); step(); step();
        expect_val("R9 falling edge irq", S_IRQ, 32'h1);
        wr(3'd5, 32'h0000_0020);

        // R10 level on pin6
        wr(3'd2, 32'h0000_0040);
        wr(3'd3, 32'h0000_0040);
        wr(3'd4, 32'h0000_0040);
        expect_val("R10 level idle", S_IRQ, 32'h0);
        pad_in[6] = 1'b1;
        step(); step();
        expect_val("R10 level high irq", S_IRQ, 32'h1);
        expect_val("R12 level wake", S_WAKE, 32'h1);
        pad_in[6] = 1'b0;
        step(); step();
        expect_val("R10 level follows", S_IRQ, 32'h0);
        wr(3'd4, 32'h0);
        expect_val("R10 level low irq", S_IRQ, 32'h1);

        // R11 disabled pins raise nothing
        wr(3'd2, 32'h0);
        expect_val("R11 disabled level", S_IRQ, 32'h0);
        expect_val("R11 disabled wake", S_WAKE, 32'h0);
        wr(3'd3, 32'h0);
        wr(3'd4, 32'h0000_0080);
        pad_in[7] = 1'b1;
        step(); step(); step();
        expect_val("R11 disabled edge irq", S_IRQ, 32'h0);
        bus_addr = 3'd5;
        expect_val("R11 disabled pending", S_RD, 32'h0);
        step(); step();

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule